// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a single pulse-width-modulated output from a 10-bit time base. The time base is an 8-bit period timer with a 2-bit sub-count below it. The sub-count advances on each prescaler tick, and the prescaler divides the input clock by 1, 4 or 16. The period is set by an 8-bit register. The pulse width is a 10-bit duty value that software writes in two parts: a high byte and a 2-bit low field inside the control register.

Software may write the duty value at any time. The value it writes is a master copy only. The comparator works against a slave copy, which is loaded from the master only when the period wraps. Because of this, a pulse already in progress is never cut short or stretched by a write. The output is a set/reset latch with these rules:
- It is set when the period wraps, unless the newly loaded duty value is zero.
- It is cleared when the time base reaches the slave duty value.

Clearing the enable bit holds the time base at zero and forces the output low. The upper byte of the slave copy can be read back through the register interface but cannot be written.

Top module: `pwm_dbuf`

## Requirements
- R1: After reset the output is low, all readback registers (period, duty high byte, control, slave high byte) read zero, and the block is disabled.
- R2: Register map at `wrAddr`/`rdAddr`:
  - Address 0 is the period register.
  - Address 1 is the duty high byte (master bits 9:2).
  - Address 2 is control: bits 1:0 are master duty bits 1:0, bit 2 is enable, and bits 4:3 select the prescale (00 = 1, 01 = 4, 1x = 16). Control reads back with bits 7:5 as zero.
  - Address 3 reads slave duty bits 9:2. Writes to address 3 change nothing.
- R3: While enabled, the sub-count advances once per prescaler tick, and the 8-bit timer advances when the sub-count wraps from 3 to 0. One period therefore lasts (period + 1) × 4 × prescale clocks.
- R4: On the tick that follows time base = {period, 3}, several things happen together: the timer and sub-count return to zero, the slave duty takes the 10-bit master value, and the output is set unless that value is zero.
- R5: The output clears on the tick where the time base becomes equal to the slave duty, so the high time is duty × prescale clocks.
- R6: A duty value of zero keeps the output low for the whole period.
- R7: A duty value of at least (period + 1) × 4 keeps the output high for the whole period.
- R8: A master duty write affects neither the output nor the slave readback until the next period wrap.
- R9: With enable at 0, the output is low from the following cycle and the time base is held at zero. After enable is set, the output stays low until the first period wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write register address |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read register address |
| rdData | output | 8 | Read data (combinational) |
| pwmOut | output | 1 | PWM output |

## Verification
The assertions check the following on every cycle:
- While the output is high, the time base lies below the slave duty.
- A zero slave duty never coexists with a high output.
- The slave copy changes only on a period wrap, and at the wrap it takes the master value with the output set accordingly.
- A cleared enable forces the output low one cycle later.

The exact lengths of the high time and the period under each prescale only show up in the bench's scenarios. The same applies to the first low period after enabling and to the one-period delay of a mid-period duty change. There, the whole waveform over three periods is compared cycle by cycle with an arithmetic model.

// File: rtl/pwmdb_pkg.sv
package pwmdb_pkg;
  localparam int ADDR_W = 2;
  localparam int PRE_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUTY   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_SLAVE  = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;   // prescaler expired: advance time base
    logic wrap;   // tick at end of period
    logic hold;   // block disabled
  } pwmStrobe_t;

  // terminal count of the prescaler for a select code
  function automatic logic [PRE_W-1:0] preLimit(input logic [1:0] sel);
    case (sel)
      2'd0:    preLimit = PRE_W'(0);
      2'd1:    preLimit = PRE_W'(3);
      default: preLimit = PRE_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/pwmdb_regs.sv
module pwmdb_regs
  import pwmdb_pkg::*;
#(
  parameter int TIMER_W = 8,
  parameter int SUB_W = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [TIMER_W-1:0]         wrData,
  input  logic [ADDR_W-1:0]          rdAddr,
  input  logic [TIMER_W+SUB_W-1:0]   slaveDuty,
  output logic [TIMER_W-1:0]         rdData,
  output logic [TIMER_W-1:0]         periodReg,
  output logic [TIMER_W+SUB_W-1:0]   masterDuty,
  output logic                       enable,
  output logic [1:0]                 presSel
);
  localparam int DUTY_W = TIMER_W + SUB_W;
  localparam int EN_BIT = SUB_W;
  localparam int PRES_LO = SUB_W + 1;
  localparam int CTRL_USED = SUB_W + 3;

  logic [TIMER_W-1:0] dutyHi;
  logic [SUB_W-1:0]   dutyLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '0;
      dutyHi    <= '0;
      dutyLo    <= '0;
      enable    <= 1'b0;
      presSel   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_PERIOD: periodReg <= wrData;
        ADDR_DUTY:   dutyHi <= wrData;
        ADDR_CTRL: begin
          dutyLo  <= wrData[SUB_W-1:0];
          enable  <= wrData[EN_BIT];
          presSel <= wrData[PRES_LO+1:PRES_LO];
        end
        default: ;  // slave copy is read-only
      endcase
    end
  end

  assign masterDuty = {dutyHi, dutyLo};

  always_comb begin
    case (rdAddr)
      ADDR_PERIOD: rdData = periodReg;
      ADDR_DUTY:   rdData = dutyHi;
      ADDR_CTRL:   rdData = TIMER_W'({presSel, enable, dutyLo});
      default:     rdData = slaveDuty[DUTY_W-1:SUB_W];
    endcase
  end

  initial begin
    if (TIMER_W < CTRL_USED) $error("control fields do not fit the data width");
  end
endmodule

// File: rtl/pwmdb_ctrl.sv
module pwmdb_ctrl
  import pwmdb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] presSel,
  input  logic       atTop,
  output pwmStrobe_t strobe
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] limit;
  logic             tick;

  assign limit = preLimit(presSel);
  assign tick  = enable && (preCnt >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (!enable) preCnt <= '0;
    else if (tick)    preCnt <= '0;
    else              preCnt <= preCnt + PRE_W'(1);
  end

  always_comb begin
    strobe.tick = tick;
    strobe.wrap = tick && atTop;
    strobe.hold = !enable;
  end
endmodule

// File: rtl/pwmdb_dp.sv
module pwmdb_dp
  import pwmdb_pkg::*;
#(
  parameter int TIMER_W = 8,
  parameter int SUB_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pwmStrobe_t               strobe,
  input  logic [TIMER_W-1:0]       periodReg,
  input  logic [TIMER_W+SUB_W-1:0] masterDuty,
  output logic                     atTop,
  output logic [TIMER_W+SUB_W-1:0] slaveDuty,
  output logic                     pwmOut
);
  localparam int DUTY_W = TIMER_W + SUB_W;

  logic [TIMER_W-1:0] timer;
  logic [SUB_W-1:0]   subCnt;
  logic [DUTY_W-1:0]  tbase;
  logic [DUTY_W-1:0]  nextTb;

  assign tbase  = {timer, subCnt};
  assign nextTb = tbase + DUTY_W'(1);
  assign atTop  = (timer == periodReg) && (subCnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer     <= '0;
      subCnt    <= '0;
      slaveDuty <= '0;
      pwmOut    <= 1'b0;
    end else if (strobe.hold) begin
      timer  <= '0;
      subCnt <= '0;
      pwmOut <= 1'b0;
    end else if (strobe.wrap) begin
      timer     <= '0;
      subCnt    <= '0;
      slaveDuty <= masterDuty;
      pwmOut    <= (masterDuty != '0);
    end else if (strobe.tick) begin
      {timer, subCnt} <= nextTb;
      if (nextTb == slaveDuty) pwmOut <= 1'b0;
    end
  end

  // R5: a high output means the time base has not yet reached the duty
  p_high_below_duty_r5: assert property (@(posedge clk) disable iff (!rstN)
    pwmOut |-> (tbase < slaveDuty));

  // R6: zero duty never drives the output high
  p_zero_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (slaveDuty == '0) |-> !pwmOut);

  // R8: slave copy only moves on a period wrap
  p_slave_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrap |=> $stable(slaveDuty));

  // R4: wrap restarts the time base and loads the slave
  p_wrap_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrap |=> (tbase == '0) && (slaveDuty == $past(masterDuty))
                    && (pwmOut == (slaveDuty != '0)));
endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf
  import pwmdb_pkg::*;
#(
  parameter int TIMER_W = 8,
  parameter int SUB_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [TIMER_W-1:0] wrData,
  input  logic [1:0]         rdAddr,
  output logic [TIMER_W-1:0] rdData,
  output logic               pwmOut
);
  localparam int DUTY_W = TIMER_W + SUB_W;

  logic [TIMER_W-1:0] periodReg;
  logic [DUTY_W-1:0]  masterDuty;
  logic [DUTY_W-1:0]  slaveDuty;
  logic               enable;
  logic [1:0]         presSel;
  logic               atTop;
  pwmStrobe_t         strobe;

  pwmdb_regs #(.TIMER_W(TIMER_W), .SUB_W(SUB_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .slaveDuty(slaveDuty), .rdData(rdData),
    .periodReg(periodReg), .masterDuty(masterDuty), .enable(enable),
    .presSel(presSel)
  );

  pwmdb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .presSel(presSel),
    .atTop(atTop), .strobe(strobe)
  );

  pwmdb_dp #(.TIMER_W(TIMER_W), .SUB_W(SUB_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .periodReg(periodReg),
    .masterDuty(masterDuty), .atTop(atTop), .slaveDuty(slaveDuty),
    .pwmOut(pwmOut)
  );

  // R9: disabled block drives the output low one cycle later
  p_off_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pwmOut);
endmodule

// File: tb/pwm_dbuf_test.sv
module pwm_dbuf_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       pwmOut;

  int total = 0;
  int bad = 0;

  pwm_dbuf uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pwmOut(pwmOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // write lands at the posedge between the two negedges
  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Enable with duty d1, switch master to d2 just after the first wrap,
  // compare three periods cycle by cycle against the arithmetic model.
  task automatic runWave(input int sel, input int p, input int d1, input int d2, input string tag);
    int s, len, changeAt, nCyc, j, k, phase, d, firstN, firstAct, firstExp;
    bit mism;
    logic expv;
    s = 1 << (2 * sel);
    len = (p + 1) * 4;
    changeAt = s * len + 1;
    nCyc = 3 * s * len;
    mism = 1'b0; firstN = 0; firstAct = 0; firstExp = 0;
    writeReg(2'd2, 8'h00);
    writeReg(2'd0, 8'(p));
    writeReg(2'd1, 8'(d1 >> 2));
    writeReg(2'd2, {3'b000, 2'(sel), 1'b1, 2'(d1)});
    for (int n = 1; n <= nCyc; n++) begin
      @(negedge clk);
      wrEn = 1'b0;
      j = n / s;
      if (j < len) expv = 1'b0;  // R9: low until the first wrap
      else begin
        k = j / len;
        phase = j % len;
        d = (k >= 2) ? d2 : d1;
        expv = (phase < d);
      end
      if (pwmOut !== expv && !mism) begin
        mism = 1'b1; firstN = n; firstAct = int'(pwmOut); firstExp = int'(expv);
      end
      if (n == changeAt) begin
        wrEn = 1'b1; wrAddr = 2'd1; wrData = 8'(d2 >> 2);
      end else if (n == changeAt + 1) begin
        wrEn = 1'b1; wrAddr = 2'd2; wrData = {3'b000, 2'(sel), 1'b1, 2'(d2)};
      end
    end
    @(negedge clk);
    wrEn = 1'b0;
    if (mism)
      $display("  mismatch at cycle %0d sel=%0d p=%0d d1=%0d d2=%0d", firstN, sel, p, d1, d2);
    check(!mism, tag, firstAct, firstExp);
  endtask

  initial begin
    logic [7:0] rv;
    int len;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(pwmOut == 1'b0, "R1 output after reset", int'(pwmOut), 0);
    for (int a = 0; a < 4; a++) begin
      readReg(2'(a), rv);
      check(rv == 8'h00, "R1 register after reset", int'(rv), 0);
    end
    idle(20);
    check(pwmOut == 1'b0, "R1 idle while disabled", int'(pwmOut), 0);

    // R2: register map and readback
    writeReg(2'd0, 8'h5A);
    readReg(2'd0, rv);
    check(rv == 8'h5A, "R2 period readback", int'(rv), 'h5A);
    writeReg(2'd1, 8'hC3);
    readReg(2'd1, rv);
    check(rv == 8'hC3, "R2 duty high readback", int'(rv), 'hC3);
    writeReg(2'd2, 8'hFB);
    readReg(2'd2, rv);
    check(rv == 8'h1B, "R2 control readback", int'(rv), 'h1B);
    writeReg(2'd3, 8'hFF);
    readReg(2'd3, rv);
    check(rv == 8'h00, "R2 slave not writable", int'(rv), 0);
    writeReg(2'd2, 8'h00);

    // R3 R4 R5 R6 R7: sweep prescale, period and every duty around the period length
    for (int sel = 0; sel < 3; sel++) begin
      for (int pi = 0; pi < 2; pi++) begin
        len = (pi * 2 + 1) * 4;
        for (int d = 0; d <= len + 1; d++) begin
          if (d == 0)        runWave(sel, pi * 2, d, d, "R6 zero duty wave");
          else if (d >= len) runWave(sel, pi * 2, d, d, "R7 full duty wave");
          else               runWave(sel, pi * 2, d, d, "R3 R4 R5 wave");
        end
      end
    end

    // R8: mid-period change applies from the next period only
    runWave(0, 3, 5, 13, "R8 change up");
    runWave(1, 3, 13, 2, "R8 change down");
    runWave(0, 2, 20, 3, "R8 full to partial");
    runWave(2, 0, 0, 3, "R8 zero to partial");

    // R8 R2: slave readback follows the wrap, not the write
    writeReg(2'd2, 8'h00);
    writeReg(2'd0, 8'd1);
    writeReg(2'd1, 8'd1);
    writeReg(2'd2, 8'h04);
    idle(10);
    readReg(2'd3, rv);
    check(rv == 8'd1, "R8 slave after first wrap", int'(rv), 1);
    writeReg(2'd1, 8'd2);
    readReg(2'd3, rv);
    check(rv == 8'd1, "R8 slave before next wrap", int'(rv), 1);
    idle(8);
    readReg(2'd3, rv);
    check(rv == 8'd2, "R8 slave after next wrap", int'(rv), 2);
    writeReg(2'd3, 8'h77);
    readReg(2'd3, rv);
    check(rv == 8'd2, "R2 slave write ignored", int'(rv), 2);

    // R9: clearing control forces the output low next cycle and keeps it low
    writeReg(2'd1, 8'hFF);
    idle(20);
    check(pwmOut == 1'b1, "R9 setup output high", int'(pwmOut), 1);
    writeReg(2'd2, 8'h00);
    @(negedge clk);
    check(pwmOut == 1'b0, "R9 cleared after disable", int'(pwmOut), 0);
    writeReg(2'd1, 8'h03);
    writeReg(2'd0, 8'h00);
    begin
      bit stayLow = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (pwmOut) stayLow = 1'b0;
      end
      check(stayLow, "R9 stays low while disabled", int'(!stayLow), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule